// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches an already-synchronised GPIO port, one pin per bit, and decides for each pin whether an interrupt condition is present. Three configuration bits per pin choose the condition. A level bit picks level or edge detection. A dual-edge bit makes edge detection fire on any change. A polarity bit selects active-high or active-low in level mode, and rising or falling in edge mode when the dual-edge bit is clear.

Level conditions are reported live. Edge events are held in a sticky status bit until software acknowledges them with a write-1-to-clear strobe. An enable register masks the raw status. One active-high interrupt line, the OR of the masked bits, feeds a shared system interrupt input. Software reads the masked vector, writes the same value to the clear strobe, and so acknowledges exactly the pins it has serviced.

Each register write is a one-cycle strobe with a shared data word. Address decoding and pin synchronisation happen outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After synchronous reset, all configuration, enable and edge status are 0, and the remembered previous pin value is 0. raw_status, masked_status and irq are then 0 until a pin event occurs.
- R2: For a pin with level bit 1, raw status bit n is 1 in the same cycle that pin_in[n] equals polarity bit n. Polarity 1 means the pin is active when high, and polarity 0 means active when low.
- R3: In level mode, a clear write has no effect on raw status while the level condition holds.
- R4: For a pin with level bit 0 and dual-edge bit 0, sticky status is set in the cycle after pin_in[n] differs from its value one clock earlier in the chosen direction. Polarity 1 selects rising (0 to 1) and polarity 0 selects falling. The status then holds until it is cleared.
- R5: With level bit 0 and dual-edge bit 1, a change in either direction sets sticky status, whatever the polarity bit holds.
- R6: masked_status equals raw_status AND the enable register. irq is 1 exactly when any masked bit is 1, and an all-zero enable silences irq.
- R7: A clear strobe with data bit n = 1 clears pin n's sticky status on the next edge. A data bit of 0 leaves that status unchanged.
- R8: If a new edge and a clear for the same pin arrive in the same cycle, the sticky status ends up set.
- R9: A write that changes a pin's level, dual-edge or polarity bit clears that pin's sticky status. This holds even if an edge is seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NPINS | Synchronised pin values |
| wr_level | input | 1 | Write strobe for the level-mode register |
| wr_dual | input | 1 | Write strobe for the dual-edge register |
| wr_polarity | input | 1 | Write strobe for the polarity register |
| wr_enable | input | 1 | Write strobe for the interrupt enable register |
| wr_clear | input | 1 | Write-1-to-clear strobe for sticky edge status |
| wr_data | input | NPINS | Data for whichever strobes are high |
| raw_status | output | NPINS | Per-pin unmasked interrupt status |
| masked_status | output | NPINS | raw_status AND enable |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The bench builds the block with its default of eight pins. At that width a single data word can give every pin a different detection mode at once. Running level-high, level-low, rising, falling and dual-edge pins side by side lets one clear or reconfiguration strobe hit pins in different modes in the same cycle. A long stretch of random pins and strobes then reaches the collisions of edge with clear, and of edge with reconfiguration, on many pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef struct packed {
        logic level;      // 1: level detection, 0: edge detection
        logic dual;       // edge mode: any change
        logic active_hi;  // level: high active; edge: rising
    } pin_cfg_t;

    function automatic logic edge_seen(pin_cfg_t c, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (c.level)
            return 1'b0;
        else if (c.dual)
            return rise | fall;
        else if (c.active_hi)
            return rise;
        else
            return fall;
    endfunction

    function automatic logic level_active(pin_cfg_t c, logic cur);
        return c.level & (cur == c.active_hi);
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_level,
    input  logic                 wr_dual,
    input  logic                 wr_polarity,
    input  logic                 wr_enable,
    input  logic [NPINS-1:0]     wr_data,
    output pin_cfg_t [NPINS-1:0] cfg_o,
    output logic [NPINS-1:0]     enable_o,
    output logic [NPINS-1:0]     reconf_o
);

    logic [NPINS-1:0] level_q, dual_q, pol_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else begin
            if (wr_level)    level_q <= wr_data;
            if (wr_dual)     dual_q  <= wr_data;
            if (wr_polarity) pol_q   <= wr_data;
            if (wr_enable)   en_q    <= wr_data;
        end
    end

    always_comb begin
        reconf_o = ({NPINS{wr_level}}    & (wr_data ^ level_q))
                 | ({NPINS{wr_dual}}     & (wr_data ^ dual_q))
                 | ({NPINS{wr_polarity}} & (wr_data ^ pol_q));
    end

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_cfg
            assign cfg_o[g].level     = level_q[g];
            assign cfg_o[g].dual      = dual_q[g];
            assign cfg_o[g].active_hi = pol_q[g];
        end
    endgenerate

    assign enable_o = en_q;

    // The enable register follows the last write on the next edge
    assert_enable_R6: assert property (@(posedge clk) disable iff (rst)
        wr_enable |=> (en_q == $past(wr_data)));

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    input  pin_cfg_t cfg_i,
    input  logic     reconf_i,
    input  logic     clr_i,
    output logic     raw_o
);

    logic prev_q;
    logic sticky_q;
    logic hit;

    assign hit = edge_seen(cfg_i, pin_i, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
            if (reconf_i)
                sticky_q <= 1'b0;
            else if (hit)
                sticky_q <= 1'b1;
            else if (clr_i)
                sticky_q <= 1'b0;
        end
    end

    assign raw_o = cfg_i.level ? level_active(cfg_i, pin_i) : sticky_q;

    assert_level_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.level && (pin_i == cfg_i.active_hi)) |-> raw_o);

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!hit && !clr_i && !reconf_i) |=> $stable(sticky_q));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !hit && !reconf_i) |=> !sticky_q);

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && !reconf_i) |=> sticky_q);

    assert_reconf_R9: assert property (@(posedge clk) disable iff (rst)
        reconf_i |=> !sticky_q);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic             wr_level,
    input  logic             wr_dual,
    input  logic             wr_polarity,
    input  logic             wr_enable,
    input  logic             wr_clear,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] raw_status,
    output logic [NPINS-1:0] masked_status,
    output logic             irq
);

    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0]     enable;
    logic [NPINS-1:0]     reconf;
    logic [NPINS-1:0]     clr_mask;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_level   (wr_level),
        .wr_dual    (wr_dual),
        .wr_polarity(wr_polarity),
        .wr_enable  (wr_enable),
        .wr_data    (wr_data),
        .cfg_o      (cfg),
        .enable_o   (enable),
        .reconf_o   (reconf)
    );

    assign clr_mask = wr_clear ? wr_data : '0;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            gpio_irq_pin u_pin (
                .clk     (clk),
                .rst     (rst),
                .pin_i   (pin_in[g]),
                .cfg_i   (cfg[g]),
                .reconf_i(reconf[g]),
                .clr_i   (clr_mask[g]),
                .raw_o   (raw_status[g])
            );
        end
    endgenerate

    assign masked_status = raw_status & enable;
    assign irq           = |masked_status;

    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

    assert_mask_subset_R6: assert property (@(posedge clk) disable iff (rst)
        ((masked_status & ~raw_status) == '0));

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
    localparam int  N      = 8;
    localparam time CLK_P  = 10;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] pin_in;
    logic wr_level, wr_dual, wr_polarity, wr_enable, wr_clear;
    logic [N-1:0] wr_data;
    logic [N-1:0] raw_status, masked_status;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [N-1:0] m_lvl, m_dual, m_pol, m_en, m_stk, m_prev;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_detect #(.NPINS(N)) i_gpio_irq_detect (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .wr_level(wr_level), .wr_dual(wr_dual), .wr_polarity(wr_polarity),
        .wr_enable(wr_enable), .wr_clear(wr_clear), .wr_data(wr_data),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    function automatic logic [N-1:0] exp_raw();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = m_lvl[i] ? (pin_in[i] == m_pol[i]) : m_stk[i];
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [N-1:0] nxt;
        if (rst) begin
            m_lvl = '0; m_dual = '0; m_pol = '0; m_en = '0; m_stk = '0; m_prev = '0;
            return;
        end
        nxt = m_stk;
        for (int i = 0; i < N; i++) begin
            bit chg, hit, up, dn;
            chg = (wr_level && wr_data[i] != m_lvl[i]) ||
                  (wr_dual && wr_data[i] != m_dual[i]) ||
                  (wr_polarity && wr_data[i] != m_pol[i]);
            up = pin_in[i] && !m_prev[i];
            dn = !pin_in[i] && m_prev[i];
            hit = 0;
            if (!m_lvl[i]) hit = m_dual[i] ? (up || dn) : (m_pol[i] ? up : dn);
            if (chg) nxt[i] = 0;
            else if (hit) nxt[i] = 1;
            else if (wr_clear && wr_data[i]) nxt[i] = 0;
        end
        m_stk = nxt;
        m_prev = pin_in;
        if (wr_level) m_lvl = wr_data;
        if (wr_dual) m_dual = wr_data;
        if (wr_polarity) m_pol = wr_data;
        if (wr_enable) m_en = wr_data;
    endtask

    // Apply inputs at a negedge, compare the outputs, then let one edge pass
    task automatic cyc(string tag, logic [N-1:0] p, logic [4:0] st, logic [N-1:0] d);
        logic [N-1:0] er;
        pin_in = p;
        {wr_level, wr_dual, wr_polarity, wr_enable, wr_clear} = st;
        wr_data = d;
        #1;
        if (!rst) begin
            er = exp_raw();
            check(tag, 32'(raw_status), 32'(er), "raw_status");
            check(tag, 32'(masked_status), 32'(er & m_en), "masked_status");
            check(tag, 32'(irq), 32'(|(er & m_en)), "irq");
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    localparam logic [4:0] S_NONE = 5'b00000, S_LVL = 5'b10000, S_DUAL = 5'b01000,
                           S_POL = 5'b00100, S_EN = 5'b00010, S_CLR = 5'b00001;

    initial begin
        #(CLK_P * 60000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1;
        @(negedge clk);
        cyc("R1", 8'h00, S_NONE, 8'h00);
        cyc("R1", 8'h00, S_NONE, 8'h00);
        rst = 0;
        cyc("R1", 8'h00, S_NONE, 8'h00);
        check("R1", 32'({raw_status, masked_status, irq}), 32'(0), "reset outputs");
        // pin0 level high, pin1 level low, pin2 rising, pin3 falling, pin4 dual
        cyc("R2", 8'h00, S_LVL,  8'h03);
        cyc("R2", 8'h00, S_POL,  8'h15);
        cyc("R5", 8'h00, S_DUAL, 8'h10);
        cyc("R6", 8'h00, S_EN,   8'hFF);
        cyc("R2", 8'h00, S_NONE, 8'h00);
        cyc("R2", 8'h01, S_NONE, 8'h00);
        cyc("R3", 8'h03, S_CLR,  8'hFF);
        cyc("R3", 8'h03, S_NONE, 8'h00);
        // edges
        cyc("R4", 8'h0C, S_NONE, 8'h00);
        cyc("R4", 8'h0C, S_NONE, 8'h00);
        cyc("R4", 8'h00, S_NONE, 8'h00);
        cyc("R4", 8'h00, S_NONE, 8'h00);
        cyc("R5", 8'h10, S_NONE, 8'h00);
        cyc("R5", 8'h10, S_CLR,  8'h10);
        cyc("R5", 8'h00, S_NONE, 8'h00);
        cyc("R5", 8'h00, S_NONE, 8'h00);
        cyc("R7", 8'h00, S_CLR,  8'h00);
        cyc("R7", 8'h00, S_NONE, 8'h00);
        cyc("R7", 8'h00, S_CLR,  8'h08);
        cyc("R7", 8'h00, S_NONE, 8'h00);
        // edge with clear in same cycle
        cyc("R8", 8'h04, S_CLR,  8'h04);
        cyc("R8", 8'h04, S_NONE, 8'h00);
        // reconfiguration clears sticky status
        cyc("R9", 8'h14, S_NONE, 8'h00);
        cyc("R9", 8'h04, S_NONE, 8'h00);
        cyc("R9", 8'h04, S_DUAL, 8'h00);
        cyc("R9", 8'h04, S_NONE, 8'h00);
        cyc("R6", 8'h04, S_EN,   8'h00);
        cyc("R6", 8'h07, S_NONE, 8'h00);
        cyc("R6", 8'h07, S_EN,   8'h04);
        cyc("R6", 8'h07, S_NONE, 8'h00);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [4:0] st;
            st = '0;
            for (int b = 0; b < 5; b++) st[b] = ($urandom_range(0, 9) == 0);
            cyc("R4", N'($urandom), st, N'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule